// File: doc/BRIEF.md
# Low-Oversampling Serial Byte Receiver

This block receives asynchronous serial bytes while looking at the line only three or four times per bit. Because the ratio is that low, a single receive channel costs a small counter instead of a sixteen-phase one. Several such channels can therefore sit side by side and keep up with back-to-back traffic at high bit rates, with no processor in the loop. The sampling rate comes from a one-cycle `tick` enable, so the system clock can run faster than the oversampling rate. The ratio is fixed when the block is built, through the parameter `OSR` (3 or 4).

The raw line first passes through a two-flop synchroniser. While the receiver is idle, the first tick that finds the synchronised line low marks the start edge. This is tick 0, and all later sampling counts from it. In 4x mode the start bit is checked once, early, to reject glitches. The start bit is then sampled at a deliberately late point: two ticks after the edge in 4x mode, one tick in 3x mode. Each following bit is sampled exactly `OSR` ticks after the one before. A finished byte appears with a one-cycle `rx_valid` strobe. A low stop bit raises `framing_error` with that strobe and makes the receiver wait for the line to go high again before it looks for a new start.

Top module: `lorx_rx`

## Requirements
- R1: The frame is: idle high, one start bit (low), 8 data bits sent least significant bit first, one stop bit (high). Every bit lasts `OSR` ticks, with `OSR` = 3 or 4. All receiver state advances only on clock edges where `tick` is high.
- R2: `rxd` passes through two synchronising flops. The start edge (tick 0) is the first tick, while idle, at which the synchronised line is low.
- R3: With `OSR`=4, the synchronised line is checked at tick 1. If it is high, the start is dropped, the receiver returns to idle and no byte is produced.
- R4: The start bit is sampled at tick 2 when `OSR`=4 and at tick 1 when `OSR`=3. A high value at that point drops the start and produces no byte.
- R5: Data bit k (k = 0..7) is sampled at tick S+`OSR`·(k+1), and the stop bit at tick S+9·`OSR`, where S is the start-sample tick of R4. The line value at all other ticks has no effect on the byte.
- R6: `rx_valid` is high for exactly one clock cycle, in the cycle after the clock edge of the stop-bit sample. `rx_data` changes only together with `rx_valid` and holds its value until the next one.
- R7: If the stop sample is low, the byte is still delivered, and `framing_error` is high in the same cycle as `rx_valid`. `framing_error` is low in every other cycle. After a low stop sample, no new start is taken until a tick has seen the synchronised line high.
- R8: After a high stop sample, a start edge on the very next tick is accepted, so frames with no idle time between them are all received.
- R9: While `rst_n` is low and after reset, `rx_valid`=0, `framing_error`=0, `rx_data`=0, and the receiver is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle enable at OSR times the bit rate |
| rxd | input | 1 | Asynchronous serial input line |
| rx_data | output | 8 | Last received byte, held until the next strobe |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| framing_error | output | 1 | High with rx_valid when the stop sample was low |

## Verification
On every cycle, the assertions check the following. The valid strobe is one cycle long. A framing error never appears without a valid strobe. The output byte only changes with a strobe. An idle tick with a low line always launches a frame. A failed early check always aborts. The receiver stays parked after a bad stop bit until the line is high. The phase counter and bit index stay in range. Only the bench scenarios show the rest. The sample instants are exactly S+OSR·(k+1): the bench drives each data bit correctly only at that tick and inverted at all the others. Short glitches produce no byte. Back-to-back frames and frames sent straight after a framing error come out complete and in order, in both 3x and 4x builds.

// File: rtl/lorx_pkg.sv
package lorx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE   = 2'd0,
    RX_ACTIVE = 2'd1,
    RX_HOLD   = 2'd2
  } rx_state_e;

  // Tick (counted from the start edge) at which each bit is sampled.
  // The late point is chosen so that slow rising edges are not misread.
  function automatic int unsigned sample_phase(input int unsigned osr);
    return (osr == 4) ? 2 : 1;
  endfunction

  // Tick at which the early glitch check runs (0 means no early check).
  function automatic int unsigned early_phase(input int unsigned osr);
    return (osr == 4) ? 1 : 0;
  endfunction

  // Absolute tick index (from tick 0) of the sample for frame slot idx,
  // where slot 0 is the start bit and slot nbits+1 is the stop bit.
  function automatic int unsigned slot_tick(input int unsigned osr,
                                            input int unsigned idx);
    return sample_phase(osr) + osr * idx;
  endfunction

endpackage

// File: rtl/lorx_sync.sv
module lorx_sync #(
  parameter int unsigned STAGES   = 2,
  parameter logic        RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain;

  generate
    genvar gi;
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[gi] <= RST_VAL;
          else        chain[gi] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[gi] <= RST_VAL;
          else        chain[gi] <= chain[gi-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/lorx_bit_timer.sv
module lorx_bit_timer
  import lorx_pkg::*;
#(
  parameter int unsigned OSR   = 4,
  parameter int unsigned NBITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic launch,
  input  logic active,
  output logic samp_en,
  output logic early_en,
  output logic at_start,
  output logic at_stop,
  output logic at_data
);

  localparam int unsigned PW    = (OSR > 2) ? $clog2(OSR) : 1;
  localparam int unsigned SLOTS = NBITS + 2;
  localparam int unsigned IW    = $clog2(SLOTS);
  localparam logic [PW-1:0] PH_LAST = PW'(OSR - 1);
  localparam logic [PW-1:0] PH_SAMP = PW'(sample_phase(OSR));
  localparam logic [PW-1:0] PH_ERLY = PW'(early_phase(OSR));
  localparam logic [IW-1:0] IX_STOP = IW'(NBITS + 1);

  logic [PW-1:0] phase_q;
  logic [IW-1:0] slot_q;
  logic          adv;
  logic          wrap;

  assign adv  = active & tick;
  assign wrap = (phase_q == PH_LAST);

  // launch is the tick-0 event, so the next tick is phase 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      slot_q  <= '0;
    end else if (launch) begin
      phase_q <= PW'(1);
      slot_q  <= '0;
    end else if (adv) begin
      if (wrap) begin
        phase_q <= '0;
        slot_q  <= slot_q + IW'(1);
      end else begin
        phase_q <= phase_q + PW'(1);
      end
    end
  end

  assign samp_en  = adv & (phase_q == PH_SAMP);
  assign at_start = (slot_q == '0);
  assign at_stop  = (slot_q == IX_STOP);
  assign at_data  = !at_start && !at_stop;

  generate
    if (early_phase(OSR) != 0) begin : g_early
      assign early_en = adv & at_start & (phase_q == PH_ERLY);
    end else begin : g_no_early
      assign early_en = 1'b0;
    end
  endgenerate

  // R1
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (phase_q <= PH_LAST));

  // R5
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (slot_q <= IX_STOP));

endmodule

// File: rtl/lorx_assembler.sv
module lorx_assembler #(
  parameter int unsigned NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             samp_en,
  input  logic             at_data,
  input  logic             at_stop,
  input  logic             line_s,
  output logic [NBITS-1:0] rx_data,
  output logic             rx_valid,
  output logic             framing_error
);

  logic [NBITS-1:0] shreg;
  logic             take_bit;
  logic             finish;

  assign take_bit = samp_en & at_data;
  assign finish   = samp_en & at_stop;

  // least significant bit arrives first, so shift in from the top
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        shreg <= '0;
    else if (take_bit) shreg <= {line_s, shreg[NBITS-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data       <= '0;
      rx_valid      <= 1'b0;
      framing_error <= 1'b0;
    end else begin
      rx_valid      <= finish;
      framing_error <= finish & ~line_s;
      if (finish) rx_data <= shreg;
    end
  end

  // R6
  valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(samp_en));

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_data));

endmodule

// File: rtl/lorx_rx.sv
module lorx_rx
  import lorx_pkg::*;
#(
  parameter int unsigned OSR         = 4,
  parameter int unsigned NBITS       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rxd,
  output logic [NBITS-1:0] rx_data,
  output logic             rx_valid,
  output logic             framing_error
);

  initial begin
    if (!(OSR == 3 || OSR == 4)) $error("lorx_rx: OSR must be 3 or 4");
  end

  rx_state_e state_q, state_d;
  logic      line_s;
  logic      launch;
  logic      samp_en, early_en;
  logic      at_start, at_stop, at_data;
  logic      glitch_abort, start_abort, stop_seen;

  lorx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(rxd),
    .q_sync (line_s)
  );

  lorx_bit_timer #(.OSR(OSR), .NBITS(NBITS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .launch  (launch),
    .active  (state_q == RX_ACTIVE),
    .samp_en (samp_en),
    .early_en(early_en),
    .at_start(at_start),
    .at_stop (at_stop),
    .at_data (at_data)
  );

  lorx_assembler #(.NBITS(NBITS)) u_asm (
    .clk          (clk),
    .rst_n        (rst_n),
    .samp_en      (samp_en),
    .at_data      (at_data),
    .at_stop      (at_stop),
    .line_s       (line_s),
    .rx_data      (rx_data),
    .rx_valid     (rx_valid),
    .framing_error(framing_error)
  );

  // named events for the checks below
  assign launch       = (state_q == RX_IDLE) & tick & ~line_s;
  assign glitch_abort = early_en & line_s;
  assign start_abort  = samp_en & at_start & line_s;
  assign stop_seen    = samp_en & at_stop;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RX_IDLE:   if (launch) state_d = RX_ACTIVE;
      RX_ACTIVE: begin
        if (glitch_abort || start_abort) state_d = RX_IDLE;
        else if (stop_seen)              state_d = line_s ? RX_IDLE : RX_HOLD;
      end
      RX_HOLD:   if (tick && line_s) state_d = RX_IDLE;
      default:   state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RX_IDLE;
    else        state_q <= state_d;
  end

  // R2
  start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_IDLE && tick && !line_s) |=> (state_q == RX_ACTIVE));

  // R3
  glitch_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    glitch_abort |=> (state_q == RX_IDLE && !rx_valid));

  // R4
  start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_abort |=> (state_q == RX_IDLE && !rx_valid));

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R7
  ferr_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    framing_error |-> rx_valid);

  // R7
  hold_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_HOLD && !(tick && line_s)) |=> (state_q == RX_HOLD));

  // R8
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_seen && line_s) |=> (state_q == RX_IDLE));

endmodule

// File: tb/lorx_rx_tb.sv
`timescale 1ns/1ps
module lorx_rx_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] tcnt = '0;
  logic       rxd4 = 1'b1, rxd3 = 1'b1;
  logic [7:0] d4, d3;
  logic       v4, v3, fe4, fe3;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  logic [8:0] q4 [0:511];
  logic [8:0] q3 [0:511];
  int wr4 = 0, rd4 = 0, wr3 = 0, rd3 = 0;

  always #4 clk = ~clk;

  // tick every 4 clocks, updated away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      tcnt <= '0;
      tick <= 1'b0;
    end else begin
      tcnt <= tcnt + 2'd1;
      tick <= (tcnt == 2'd3);
    end
  end

  lorx_rx #(.OSR(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd4),
    .rx_data(d4), .rx_valid(v4), .framing_error(fe4));

  lorx_rx #(.OSR(3)) u_dut3 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd3),
    .rx_data(d3), .rx_valid(v3), .framing_error(fe3));

  function automatic int osr_of(input int sel);
    return (sel != 0) ? 3 : 4;
  endfunction

  function automatic int samp_of(input int osr);
    return (osr == 4) ? 2 : 1;
  endfunction

  // expected record: {framing_error, byte}
  function automatic logic [8:0] exp_word(input logic [7:0] b, input bit stop_hi);
    return {~stop_hi, b};
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitors, sampled at the falling edge
  logic [7:0] prev4 = '0, prev3 = '0;
  logic       pv4 = 0, pv3 = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (v4) begin
        if (rd4 >= wr4) check(0, "R3/R4/R7 unexpected byte (4x)", {8'h0, d4}, 16'h0);
        else begin
          check({fe4, d4} === q4[rd4[8:0]], "R5/R7 byte (4x)", {7'h0, fe4, d4}, {7'h0, q4[rd4[8:0]]});
          rd4++;
        end
      end
      if (v3) begin
        if (rd3 >= wr3) check(0, "R3/R4/R7 unexpected byte (3x)", {8'h0, d3}, 16'h0);
        else begin
          check({fe3, d3} === q3[rd3[8:0]], "R5/R7 byte (3x)", {7'h0, fe3, d3}, {7'h0, q3[rd3[8:0]]});
          rd3++;
        end
      end
      if (!v4 && d4 !== prev4) check(0, "R6 data changed without valid (4x)", {8'h0, d4}, {8'h0, prev4});
      if (!v3 && d3 !== prev3) check(0, "R6 data changed without valid (3x)", {8'h0, d3}, {8'h0, prev3});
      if (v4 && pv4) check(0, "R6 valid longer than one cycle (4x)", 16'd2, 16'd1);
      if (v3 && pv3) check(0, "R6 valid longer than one cycle (3x)", 16'd2, 16'd1);
      if (fe4 && !v4) check(0, "R7 framing_error without valid (4x)", 16'd1, 16'd0);
      if (fe3 && !v3) check(0, "R7 framing_error without valid (3x)", 16'd1, 16'd0);
      prev4 = d4; prev3 = d3; pv4 = v4; pv3 = v3;
    end
  end

  task automatic one_tick();
    @(posedge clk);
    while (tick !== 1'b1) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_line(input int sel, input logic val);
    if (sel != 0) rxd3 = val;
    else          rxd4 = val;
  endtask

  task automatic push(input int sel, input logic [8:0] w);
    if (sel != 0) begin q3[wr3[8:0]] = w; wr3++; end
    else          begin q4[wr4[8:0]] = w; wr4++; end
  endtask

  // pinpoint: data bits are correct only at the sample tick, inverted elsewhere
  task automatic send(input int sel, input logic [7:0] b, input bit stop_hi,
                      input int hold_low, input bit pinpoint);
    int osr = osr_of(sel);
    int sp  = samp_of(osr);
    push(sel, exp_word(b, stop_hi));
    set_line(sel, 1'b0);
    repeat (osr) one_tick();
    for (int k = 0; k < 8; k++) begin
      for (int o = 0; o < osr; o++) begin
        set_line(sel, (pinpoint && o != sp) ? ~b[k] : b[k]);
        one_tick();
      end
    end
    set_line(sel, stop_hi);
    repeat (osr) one_tick();
    if (!stop_hi) begin
      repeat (hold_low) one_tick();
      set_line(sel, 1'b1);
      one_tick();
    end
  endtask

  task automatic glitch(input int sel, input int nlow);
    set_line(sel, 1'b0);
    repeat (nlow) one_tick();
    set_line(sel, 1'b1);
    repeat (2 * osr_of(sel)) one_tick();
  endtask

  task automatic drain_check(input string tag);
    repeat (8) one_tick();
    check(rd4 == wr4, tag, 16'(rd4), 16'(wr4));
    check(rd3 == wr3, tag, 16'(rd3), 16'(wr3));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R9 during reset
    check(v4 === 1'b0 && fe4 === 1'b0 && d4 === 8'h00, "R9 reset outputs (4x)", {6'h0, v4, fe4, d4}, 16'h0);
    check(v3 === 1'b0 && fe3 === 1'b0 && d3 === 8'h00, "R9 reset outputs (3x)", {6'h0, v3, fe3, d3}, 16'h0);
    rst_n = 1'b1;
    repeat (4) one_tick();
    check(v4 === 1'b0 && d4 === 8'h00, "R9 after reset (4x)", {7'h0, v4, d4}, 16'h0);
    check(v3 === 1'b0 && d3 === 8'h00, "R9 after reset (3x)", {7'h0, v3, d3}, 16'h0);

    // R1 directed patterns, both ratios
    for (int s = 0; s < 2; s++) begin
      send(s, 8'h00, 1, 0, 0);
      send(s, 8'hFF, 1, 0, 0);
      send(s, 8'hA5, 1, 0, 0);
      send(s, 8'h01, 1, 0, 0);
      send(s, 8'h80, 1, 0, 0);
    end
    drain_check("R1 directed frames all received");

    // R5 exact sample tick
    for (int s = 0; s < 2; s++) begin
      send(s, 8'h5A, 1, 0, 1);
      send(s, 8'hC3, 1, 0, 1);
    end
    drain_check("R5 pinpoint frames all received");

    // R8 back-to-back frames with no idle
    for (int s = 0; s < 2; s++) begin
      send(s, 8'h12, 1, 0, 0);
      send(s, 8'h34, 1, 0, 1);
      send(s, 8'h56, 1, 0, 0);
    end
    drain_check("R8 back-to-back frames all received");

    // R3 one-tick glitch, R4 start sample high (4x two-tick glitch)
    glitch(0, 1);
    glitch(1, 1);
    glitch(0, 2);
    drain_check("R3/R4 glitches produce no byte");
    send(0, 8'h3C, 1, 0, 1);
    send(1, 8'h3C, 1, 0, 1);
    drain_check("R3/R4 alignment after glitch");

    // R7 framing error, long low hold, then a frame right after
    for (int s = 0; s < 2; s++) begin
      send(s, 8'h99, 0, 7, 0);
      send(s, 8'h66, 1, 0, 0);
      send(s, 8'h0F, 0, 0, 0);
      send(s, 8'hF0, 1, 0, 1);
    end
    drain_check("R7 framing error frames");

    // random mix
    for (int i = 0; i < 60; i++) begin
      int s = int'($urandom_range(0, 1));
      logic [7:0] b = 8'($urandom());
      bit st = ($urandom_range(0, 7) != 0);
      int gap = int'($urandom_range(0, 3));
      send(s, b, st, int'($urandom_range(0, 5)), bit'($urandom_range(0, 1)));
      repeat (gap) one_tick();
      if ($urandom_range(0, 9) == 0) glitch(s, 1);
    end
    drain_check("R1/R5/R7 random frames");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule